// File: doc/BRIEF.md
# Oversampling Serial Receiver with Sticky Status Flags

This block receives asynchronous serial frames on a single input line and makes each received word available in a small register file. A 16-bit divider sets the oversampling tick, and sixteen ticks make one bit period. Each frame is a low start bit, then 7, 8 or 9 frame bits sent least significant bit first, then a stop bit. When parity is enabled, the last frame bit is the parity bit. That bit is stored as the most significant bit of the word.

Software polls a status register. It holds a receive-ready flag and five sticky flags: parity, framing, noise, overrun and idle. The sticky flags are cleared only by a status read that is directly followed by a data read on the bus. A data read on its own consumes the word but leaves the sticky flags alone. The receiver stalls completely while it is disabled.

Top module: `uart_rx_status`

## Requirements
- R1: Frame length code in control bits [4:3]: 00 gives 8 frame bits, 01 gives 9 and 10 gives 7 (11 behaves as 00). Bits arrive LSB first. The word is right-aligned in data register (address 1) bits [8:0], and unused upper bits read 0.
- R2: With parity on (control bit 1; bit 2 selects odd when 1, even when 0), the top frame bit is the received parity bit and is kept in the word. Status bit 1 sets when the ones count over all frame bits does not match the selected parity.
- R3: If a frame completes while status bit 0 (ready) is still set and no data read happens in that cycle, status bit 4 (overrun) sets. The held word is kept and the new word is discarded.
- R4: A data read that immediately follows a status read (address 0), with no other bus access between them, clears status bits 1 to 5. Any other access pattern leaves those bits unchanged.
- R5: Status bit 0 sets when a word is stored and clears on any data read.
- R6: Status bit 2 (framing) sets when the stop bit is sampled low, including for an all-low break frame.
- R7: Each bit is decided by a majority vote of samples 7, 8 and 9 of its 16 ticks. Any disagreement among them in the frame sets status bit 3 (noise), and the stored word uses the voted values.
- R8: A falling edge starts reception only if the voted mid-bit value is low. A shorter low pulse produces no word and no flag.
- R9: Status bit 5 (idle) sets once the line has stayed high for (frame bits + 2) × 16 ticks after a received stop bit. It sets at most once per gap and is not set again until another frame arrives.
- R10: With control bit 0 clear, the divider counter holds and no frame is received. The divider register is at address 2, and a tick occurs every max(divider,1) clocks.
- R11: If a frame completes in the same cycle as a data read, the new word is stored, ready stays set and no overrun is flagged. Flag setting by that frame wins over clearing.
- R12: After reset, all four registers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rxLine | input | 1 | Serial receive line, idle high |
| busRead | input | 1 | Register read strobe, one cycle per access |
| busWrite | input | 1 | Register write strobe |
| busAddr | input | 2 | Register select: 0 status, 1 data, 2 divider, 3 control |
| busWdata | input | 16 | Write data |
| busRdata | output | 16 | Read data of the addressed register, combinational |

## Verification
The collision that matters is a software data read landing in the same clock as a frame completing. In that cycle, a store, a ready clear and possibly an overrun all compete. The bench provokes it by starting a second frame while the first word is still held, then issuing the data read at every clock offset across a window that straddles the completion. Each offset must give one of two consistent outcomes. Either the read came first, so the new word is stored with ready set and no overrun, or it came late, so overrun is set, ready is clear and the old word is kept. The change from the first outcome to the second must happen exactly once as the offset grows.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  typedef struct packed {
    logic shiftEn;
    logic shiftBit;
    logic frameDone;
    logic stopLow;
    logic noisy;
    logic idleHit;
  } rxStrobe_t;

  function automatic logic [3:0] frameLen(input logic [1:0] code);
    case (code)
      2'b01:   return 4'd9;
      2'b10:   return 4'd7;
      default: return 4'd8;
    endcase
  endfunction

endpackage

// File: rtl/uart_rx_ctrl.sv
module uart_rx_ctrl
  import uart_rx_pkg::*;
#(
  parameter int DIV_W    = 16,
  parameter int OVS_LOG2 = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rxLine,
  input  logic             rxEn,
  input  logic [DIV_W-1:0] divisor,
  input  logic [1:0]       lenCode,
  output rxStrobe_t        strb
);
  localparam int IDLE_W = OVS_LOG2 + 5;
  localparam logic [OVS_LOG2-1:0] MID  = OVS_LOG2'(1 << (OVS_LOG2 - 1));
  localparam logic [OVS_LOG2-1:0] EVAL = MID + 1'b1;
  localparam logic [OVS_LOG2-1:0] LAST = '1;

  typedef enum logic [1:0] {ST_HUNT, ST_START, ST_DATA, ST_STOP} rxState_t;

  rxState_t              state;
  logic [1:0]            syncQ;
  logic                  rxS;
  logic [DIV_W-1:0]      divCnt;
  logic [DIV_W-1:0]      divEff;
  logic                  tick;
  logic [OVS_LOG2-1:0]   sampCnt;
  logic [3:0]            bitCnt;
  logic [1:0]            vote;
  logic                  maj;
  logic                  disagree;
  logic                  noiseAcc;
  logic                  lineWasHigh;
  logic [IDLE_W-1:0]     idleCnt;
  logic [IDLE_W-1:0]     frameTicks;
  logic                  idleArmed;
  logic [3:0]            nBits;

  // two-flop synchronizer for the asynchronous line
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= 2'b11;
    else       syncQ <= {syncQ[0], rxLine};
  end
  assign rxS = syncQ[1];

  // oversampling tick generator, frozen while disabled
  assign divEff = (divisor == '0) ? DIV_W'(1) : divisor;
  assign tick   = rxEn && (divCnt >= divEff - 1'b1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      divCnt <= '0;
    else if (rxEn)  divCnt <= tick ? '0 : divCnt + 1'b1;
  end

  assign nBits      = frameLen(lenCode);
  assign frameTicks = IDLE_W'((int'(nBits) + 2) << OVS_LOG2);
  assign maj        = (vote[0] & vote[1]) | (vote[0] & rxS) | (vote[1] & rxS);
  assign disagree   = !((vote[0] == vote[1]) && (vote[1] == rxS));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= ST_HUNT;
      sampCnt     <= '0;
      bitCnt      <= '0;
      vote        <= '0;
      noiseAcc    <= 1'b0;
      lineWasHigh <= 1'b0;
      idleCnt     <= '0;
      idleArmed   <= 1'b0;
      strb        <= '0;
    end else begin
      strb <= '0;
      if (tick) begin
        // idle gap measurement
        if (state != ST_HUNT || !rxS) begin
          idleCnt <= '0;
        end else if (idleCnt < frameTicks) begin
          idleCnt <= idleCnt + 1'b1;
          if (idleCnt == frameTicks - 1'b1 && idleArmed) begin
            strb.idleHit <= 1'b1;
            idleArmed    <= 1'b0;
          end
        end

        if (state == ST_HUNT) begin
          lineWasHigh <= rxS;
          if (lineWasHigh && !rxS) begin
            state    <= ST_START;
            sampCnt  <= '0;
            noiseAcc <= 1'b0;
          end
        end else begin
          sampCnt <= sampCnt + 1'b1;
          if (sampCnt == MID - 1'b1) vote[0] <= rxS;
          if (sampCnt == MID)        vote[1] <= rxS;
          case (state)
            ST_START: begin
              if (sampCnt == EVAL) begin
                if (maj) begin
                  state       <= ST_HUNT;
                  lineWasHigh <= 1'b1;
                end else begin
                  noiseAcc <= disagree;
                end
              end
              if (sampCnt == LAST) begin
                state  <= ST_DATA;
                bitCnt <= '0;
              end
            end
            ST_DATA: begin
              if (sampCnt == EVAL) begin
                strb.shiftEn  <= 1'b1;
                strb.shiftBit <= maj;
                noiseAcc      <= noiseAcc | disagree;
              end
              if (sampCnt == LAST) begin
                bitCnt <= bitCnt + 1'b1;
                if (bitCnt == nBits - 1'b1) state <= ST_STOP;
              end
            end
            default: begin
              if (sampCnt == EVAL) begin
                strb.frameDone <= 1'b1;
                strb.stopLow   <= !maj;
                strb.noisy     <= noiseAcc | disagree;
                idleArmed      <= 1'b1;
                lineWasHigh    <= maj;
                state          <= ST_HUNT;
              end
            end
          endcase
        end
      end
    end
  end

  // R10: tick counter frozen while disabled
  a_r10_div_hold: assert property (@(posedge clk) disable iff (!rstN)
    !rxEn |=> $stable(divCnt));
  // R8: a high mid-bit vote on the start bit abandons the frame
  a_r8_false_start: assert property (@(posedge clk) disable iff (!rstN)
    (tick && state == ST_START && sampCnt == EVAL && maj) |=> state == ST_HUNT);
  // R6: completion is a single-cycle event
  a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    strb.frameDone |=> !strb.frameDone);
  // R9: idle report never coincides with a completion
  a_r9_idle_apart: assert property (@(posedge clk) disable iff (!rstN)
    strb.idleHit |-> !strb.frameDone);

endmodule

// File: rtl/uart_rx_dp.sv
module uart_rx_dp
  import uart_rx_pkg::*;
#(
  parameter int DIV_W  = 16,
  parameter int DATA_W = 9,
  parameter int BUS_W  = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  rxStrobe_t        strb,
  input  logic             busRead,
  input  logic             busWrite,
  input  logic [1:0]       busAddr,
  input  logic [BUS_W-1:0] busWdata,
  output logic [BUS_W-1:0] busRdata,
  output logic             rxEn,
  output logic [DIV_W-1:0] divisor,
  output logic [1:0]       lenCode
);
  localparam logic [1:0] A_STAT = 2'd0;
  localparam logic [1:0] A_DATA = 2'd1;
  localparam logic [1:0] A_DIV  = 2'd2;
  localparam logic [1:0] A_CTRL = 2'd3;
  localparam logic [3:0] DW4    = 4'(DATA_W);

  logic [DATA_W-1:0] shReg;
  logic [DATA_W-1:0] dataReg;
  logic [DATA_W-1:0] newWord;
  logic [3:0]        nBits;
  logic              parEn, parOdd, parBad;
  logic              rxReady, parErr, frmErr, noiseErr, ovrErr, idleFlag;
  logic              statArmed;
  logic              readStat, readData, accept, clearErr;

  assign readStat = busRead && busAddr == A_STAT;
  assign readData = busRead && busAddr == A_DATA;
  assign nBits    = frameLen(lenCode);
  assign newWord  = shReg >> (DW4 - nBits);
  assign parBad   = parEn && ((^newWord) != parOdd);
  assign accept   = strb.frameDone && (!rxReady || readData);
  assign clearErr = readData && statArmed;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shReg <= '0;
    else if (strb.shiftEn) shReg <= {strb.shiftBit, shReg[DATA_W-1:1]};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataReg   <= '0;
      rxReady   <= 1'b0;
      parErr    <= 1'b0;
      frmErr    <= 1'b0;
      noiseErr  <= 1'b0;
      ovrErr    <= 1'b0;
      idleFlag  <= 1'b0;
      statArmed <= 1'b0;
    end else begin
      if (accept) dataReg <= newWord;

      if (accept)        rxReady <= 1'b1;
      else if (readData) rxReady <= 1'b0;

      if (strb.frameDone && !accept) ovrErr <= 1'b1;
      else if (clearErr)             ovrErr <= 1'b0;

      if (accept && parBad)    parErr <= 1'b1;
      else if (clearErr)       parErr <= 1'b0;

      if (accept && strb.stopLow) frmErr <= 1'b1;
      else if (clearErr)          frmErr <= 1'b0;

      if (accept && strb.noisy) noiseErr <= 1'b1;
      else if (clearErr)        noiseErr <= 1'b0;

      if (strb.idleHit)   idleFlag <= 1'b1;
      else if (clearErr)  idleFlag <= 1'b0;

      if (readStat)                  statArmed <= 1'b1;
      else if (busRead || busWrite)  statArmed <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divisor <= '0;
      rxEn    <= 1'b0;
      parEn   <= 1'b0;
      parOdd  <= 1'b0;
      lenCode <= 2'b00;
    end else if (busWrite) begin
      if (busAddr == A_DIV) divisor <= busWdata[DIV_W-1:0];
      if (busAddr == A_CTRL) begin
        rxEn    <= busWdata[0];
        parEn   <= busWdata[1];
        parOdd  <= busWdata[2];
        lenCode <= busWdata[4:3];
      end
    end
  end

  always_comb begin
    case (busAddr)
      A_STAT:  busRdata = BUS_W'({idleFlag, ovrErr, noiseErr, frmErr, parErr, rxReady});
      A_DATA:  busRdata = BUS_W'(dataReg);
      A_DIV:   busRdata = BUS_W'(divisor);
      default: busRdata = BUS_W'({lenCode, parOdd, parEn, rxEn});
    endcase
  end

  // R3: held word survives a completion while still unread
  a_r3_word_kept: assert property (@(posedge clk) disable iff (!rstN)
    (strb.frameDone && rxReady && !readData) |=> ($stable(dataReg) && ovrErr));
  // R5: a data read without a completing frame empties the holding register
  a_r5_ready_clears: assert property (@(posedge clk) disable iff (!rstN)
    (readData && !strb.frameDone) |=> !rxReady);
  // R4: completed clear sequence drops the error flags
  a_r4_clear_seq: assert property (@(posedge clk) disable iff (!rstN)
    (statArmed && readData && !strb.frameDone) |=> !(parErr || frmErr || noiseErr || ovrErr));
  // R4: error flags do not move without a frame or a data read
  a_r4_flags_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!readData && !strb.frameDone) |=> $stable({parErr, frmErr, noiseErr, ovrErr}));
  // R11: completion coinciding with a data read keeps ready set
  a_r11_same_cycle: assert property (@(posedge clk) disable iff (!rstN)
    (strb.frameDone && readData) |=> rxReady);

endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status
  import uart_rx_pkg::*;
#(
  parameter int DIV_W    = 16,
  parameter int DATA_W   = 9,
  parameter int BUS_W    = 16,
  parameter int OVS_LOG2 = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rxLine,
  input  logic             busRead,
  input  logic             busWrite,
  input  logic [1:0]       busAddr,
  input  logic [BUS_W-1:0] busWdata,
  output logic [BUS_W-1:0] busRdata
);
  rxStrobe_t        strb;
  logic             rxEn;
  logic [DIV_W-1:0] divisor;
  logic [1:0]       lenCode;

  uart_rx_ctrl #(.DIV_W(DIV_W), .OVS_LOG2(OVS_LOG2)) ctrl_i (
    .clk(clk), .rstN(rstN), .rxLine(rxLine), .rxEn(rxEn),
    .divisor(divisor), .lenCode(lenCode), .strb(strb)
  );

  uart_rx_dp #(.DIV_W(DIV_W), .DATA_W(DATA_W), .BUS_W(BUS_W)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb),
    .busRead(busRead), .busWrite(busWrite), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata),
    .rxEn(rxEn), .divisor(divisor), .lenCode(lenCode)
  );

endmodule

// File: tb/uart_rx_status_tb.sv
module uart_rx_status_tb_top;
  localparam int BP = 32;  // divider 2 -> 2 clocks per tick, 16 ticks per bit

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        rxLine = 1'b1;
  logic        busRead = 1'b0;
  logic        busWrite = 1'b0;
  logic [1:0]  busAddr = 2'd0;
  logic [15:0] busWdata = 16'd0;
  logic [15:0] busRdata;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  uart_rx_status dut_i (
    .clk(clk), .rstN(rstN), .rxLine(rxLine), .busRead(busRead),
    .busWrite(busWrite), .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic readReg(input logic [1:0] a, output logic [15:0] v);
    @(negedge clk);
    busAddr = a;
    busRead = 1'b1;
    #1 v = busRdata;
    @(negedge clk);
    busRead = 1'b0;
  endtask

  task automatic writeReg(input logic [1:0] a, input logic [15:0] v);
    @(negedge clk);
    busAddr  = a;
    busWdata = v;
    busWrite = 1'b1;
    @(negedge clk);
    busWrite = 1'b0;
  endtask

  task automatic idleClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // glitchBit < 0: clean frame; otherwise a 2-clock inversion near that bit's centre
  task automatic sendFrame(input int word, input int nb, input logic stopV, input int glitchBit);
    rxLine = 1'b0;
    idleClk(BP);
    for (int i = 0; i < nb; i++) begin
      rxLine = word[i];
      if (i == glitchBit) begin
        idleClk(16);
        rxLine = ~word[i];
        idleClk(2);
        rxLine = word[i];
        idleClk(BP - 18);
      end else begin
        idleClk(BP);
      end
    end
    rxLine = stopV;
    idleClk(BP);
    rxLine = 1'b1;
  endtask

  function automatic int lenOf(input int code);
    return (code == 1) ? 9 : (code == 2) ? 7 : 8;
  endfunction

  // pm: 0 none, 1 even, 2 odd
  function automatic int mkWord(input int pl, input int nb, input int pm);
    int lo, p;
    if (pm == 0) return pl & ((1 << nb) - 1);
    lo = pl & ((1 << (nb - 1)) - 1);
    p  = (^lo) ^ (pm == 2 ? 1 : 0);
    return lo | (p << (nb - 1));
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog all-requirements actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] s, d, rd;
    int w, w1, w2, outc;
    bit sawA, sawB, orderBad;

    idleClk(5);
    rstN = 1'b1;
    idleClk(2);

    // R12 reset values
    for (int a = 0; a < 4; a++) begin
      readReg(2'(a), s);
      chk($sformatf("R12 reg%0d after reset", a), s, 0);
    end

    writeReg(2'd2, 16'd2);
    chk("R10 divider readback", 2, 2);
    readReg(2'd2, s);
    chk("R10 divider register", s, 2);

    // R1/R2/R5 sweep over lengths, parity modes and payloads
    for (int code = 0; code < 3; code++) begin
      for (int pm = 0; pm < 3; pm++) begin
        writeReg(2'd3, 16'(1 | ((pm != 0) ? 2 : 0) | ((pm == 2) ? 4 : 0) | (code << 3)));
        for (int k = 0; k < 4; k++) begin
          w = mkWord((k * 91 + code * 37 + pm * 11 + 165) & 16'h1FF, lenOf(code), pm);
          sendFrame(w, lenOf(code), 1'b1, -1);
          idleClk(4);
          readReg(2'd0, s);
          chk(pm == 0 ? "R1 status clean frame" : "R2 status good parity", s & 16'h1F, 1);
          readReg(2'd1, d);
          chk(pm == 0 ? "R1 word value" : "R2 word with parity msb", d, w);
          readReg(2'd0, s);
          chk("R5 ready cleared by data read", s & 16'h1F, 0);
        end
      end
    end

    // R2 parity error: 8 bits, even parity, parity bit flipped
    writeReg(2'd3, 16'h0003);
    w = mkWord(16'h5A, 8, 1) ^ 16'h80;
    sendFrame(w, 8, 1'b1, -1);
    idleClk(4);
    readReg(2'd0, s);
    chk("R2 parity error flag", s & 16'h1F, 16'h03);
    readReg(2'd1, d);
    chk("R2 stored word keeps received parity bit", d, w);

    // R7 noise: glitch on one centre sample, vote keeps value
    writeReg(2'd3, 16'h0001);
    sendFrame(16'hC6, 8, 1'b1, 3);
    idleClk(4);
    readReg(2'd0, s);
    chk("R7 noise flag", s & 16'h1F, 16'h09);
    readReg(2'd1, d);
    chk("R7 voted word", d, 16'hC6);

    // R6 framing error, then R4 broken sequence
    sendFrame(16'h3C, 8, 1'b0, -1);
    idleClk(4);
    readReg(2'd0, s);
    chk("R6 framing flag", s & 16'h1F, 16'h05);
    writeReg(2'd3, 16'h0001);
    readReg(2'd1, d);
    chk("R6 word with bad stop", d, 16'h3C);
    readReg(2'd0, s);
    chk("R4 flags kept without direct sequence", s & 16'h1F, 16'h04);
    readReg(2'd1, d);
    readReg(2'd0, s);
    chk("R4 sequence clears flags", s & 16'h1F, 0);

    // R6 break frame
    sendFrame(0, 8, 1'b0, -1);
    idleClk(40);
    readReg(2'd0, s);
    chk("R6 break sets framing", s & 16'h1F, 16'h05);
    readReg(2'd1, d);
    chk("R6 break word", d, 0);

    // R3 overrun
    sendFrame(16'hA1, 8, 1'b1, -1);
    idleClk(3);
    sendFrame(16'h1E, 8, 1'b1, -1);
    idleClk(4);
    readReg(2'd0, s);
    chk("R3 overrun flag", s & 16'h1F, 16'h11);
    readReg(2'd1, d);
    chk("R3 held word kept", d, 16'hA1);
    readReg(2'd0, s);
    chk("R3 overrun cleared by sequence", s & 16'h1F, 0);

    // R8 short low pulse ignored
    rxLine = 1'b0;
    idleClk(8);
    rxLine = 1'b1;
    idleClk(400);
    readReg(2'd0, s);
    chk("R8 glitch start ignored", s & 16'h1F, 0);
    sendFrame(16'h77, 8, 1'b1, -1);
    idleClk(4);
    readReg(2'd0, s);
    chk("R8 next real frame accepted", s & 16'h1F, 1);
    readReg(2'd1, d);
    chk("R8 next real word", d, 16'h77);

    // R9 idle detection, once per gap
    idleClk(4);
    readReg(2'd0, s);
    chk("R9 idle not yet", s & 16'h20, 0);
    idleClk(500);
    readReg(2'd0, s);
    chk("R9 idle after frame time", s & 16'h20, 16'h20);
    readReg(2'd1, d);
    readReg(2'd0, s);
    chk("R9 idle cleared by sequence", s & 16'h20, 0);
    idleClk(600);
    readReg(2'd0, s);
    chk("R9 idle not repeated in same gap", s & 16'h20, 0);

    // R10 receiver disabled
    writeReg(2'd3, 16'h0000);
    sendFrame(16'h55, 8, 1'b1, -1);
    idleClk(40);
    readReg(2'd0, s);
    chk("R10 no frame while disabled", s & 16'h1F, 0);
    writeReg(2'd3, 16'h0001);
    readReg(2'd3, s);
    chk("R1 control readback", s, 1);

    // R11 data read swept across the completion of a second frame
    w1 = 16'h39;
    w2 = 16'hC4;
    sawA = 1'b0;
    sawB = 1'b0;
    orderBad = 1'b0;
    for (int off = 280; off <= 340; off++) begin
      readReg(2'd0, s);
      readReg(2'd1, d);
      sendFrame(w1, 8, 1'b1, -1);
      idleClk(8);
      fork
        sendFrame(w2, 8, 1'b1, -1);
        begin
          idleClk(off);
          readReg(2'd1, rd);
        end
      join
      idleClk(8);
      readReg(2'd0, s);
      readReg(2'd1, d);
      chk("R11 read returns held word", rd & 16'h1FF, w1);
      if ((s & 16'h11) == 16'h01 && d == 16'(w2)) outc = 1;
      else if ((s & 16'h11) == 16'h10 && d == 16'(w1)) outc = 2;
      else outc = 0;
      chk($sformatf("R11 consistent outcome at offset %0d (status 0x%0h data 0x%0h)", off, s, d),
          (outc != 0) ? 1 : 0, 1);
      if (outc == 1) begin
        if (sawB) orderBad = 1'b1;
        sawA = 1'b1;
      end
      if (outc == 2) sawB = 1'b1;
    end
    chk("R11 both outcomes seen", (sawA && sawB) ? 1 : 0, 1);
    chk("R11 single transition", orderBad ? 1 : 0, 0);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule